// File: doc/BRIEF.md
# Activation and Requantization Pipeline

This block takes finished 32-bit signed accumulator sums and turns each one into an unsigned 8-bit code. The sums arrive one per beat. Each sum is a fixed-point number with 8 fractional bits, so the value 256 stands for 1.0. A sum must only be presented once it is complete; the block never sees a partial sum. The block first applies a fixed nonlinearity chosen for that beat: pass-through, rectifier, a piecewise-linear sigmoid, or a piecewise-linear tanh. It then maps the result onto 256 codes, using a per-beat offset (the real value that maps to code 0) and a per-beat fixed-point gain.

Both sides use a valid/ready handshake. The data path has three register stages: nonlinearity, offset-and-gain, then round-and-clamp. With the consumer always ready, the block accepts one beat every clock. When the consumer stalls, the stall propagates back to the input through the ready signal, and no beat is lost or repeated.

Top module: `actq_pipe`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: With function code 2'b00 (pass-through), the activated value equals the input sum.
- R3: With function code 2'b01 (rectifier), a negative sum becomes 0 and a non-negative sum passes unchanged.
- R4: With function code 2'b10 (sigmoid), x >= 1024 (4.0) gives 256 (1.0) and x <= -1024 gives 0. Between those limits the result is 128 + floor(x/8).
- R5: With function code 2'b11 (tanh), x >= 1024 gives 256 and x <= -1024 gives -256. Otherwise, with m = |x|, the magnitude is floor(3m/8) for m < 512 and 192 + floor((m-512)/8) for m >= 512, and the sign of x is kept.
- R6: With activated value y, offset in_min (same 8-fraction-bit format, signed) and gain in_scale (unsigned, 16 fractional bits), the code is floor(((y - in_min) * in_scale + 32768) / 65536).
- R7: A code below 0 is output as 0, and a code above 255 is output as 255.
- R8: A code that lands exactly halfway between two integers rounds up.
- R9: With out_ready held high, a beat accepted at a clock edge appears on out_code three clock edges later, and back-to-back beats are accepted with no stall.
- R10: While out_valid is 1 and out_ready is 0, out_code stays stable. in_ready falls once all three stages hold data. Beats leave in the order they were accepted, with none lost.
- R11: The function code, offset and gain are captured with each beat, so neighbouring beats may use different settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take the input beat |
| in_acc | input | 32 | Completed accumulator sum, signed, 8 fractional bits |
| in_fn | input | 2 | Nonlinearity select for this beat |
| in_min | input | 32 | Real value mapped to code 0, signed, 8 fractional bits |
| in_scale | input | 24 | Codes per input unit, unsigned, 16 fractional bits |
| out_valid | output | 1 | Output code present |
| out_ready | input | 1 | Consumer takes the output code |
| out_code | output | 8 | Requantized 8-bit code |

## Verification
The assertions assume that in_fn and in_acc hold known values whenever in_valid is high. They also assume that the consumer reads out_code only while out_valid is high. The range assertions on the nonlinearity check every accepted beat, whatever sum it carries. Every directed scenario drives each input from a task that holds a beat steady until in_ready accepts it. The stall scenario keeps in_valid high with fixed data for the whole time in_ready is low, so the assertions and the scoreboard see the same set of accepted beats.

// File: rtl/actq_pkg.sv
package actq_pkg;

  typedef enum logic [1:0] {
    FN_PASS = 2'b00,
    FN_RECT = 2'b01,
    FN_SIGM = 2'b10,
    FN_TANH = 2'b11
  } act_fn_e;

endpackage

// File: rtl/actq_fn_stage.sv
module actq_fn_stage #(
  parameter int ACC_W   = 32,
  parameter int FRAC    = 8,
  parameter int SCALE_W = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      adv,
  input  logic                      load,
  input  logic signed [ACC_W-1:0]   acc_i,
  input  logic [1:0]                fn_i,
  input  logic signed [ACC_W-1:0]   min_i,
  input  logic [SCALE_W-1:0]        scale_i,
  output logic                      vld_o,
  output logic signed [ACC_W-1:0]   act_o,
  output logic signed [ACC_W-1:0]   min_o,
  output logic [SCALE_W-1:0]        scale_o
);
  import actq_pkg::*;

  localparam logic signed [ACC_W-1:0] ONE     = ACC_W'(1) <<< FRAC;
  localparam logic signed [ACC_W-1:0] HALF    = ONE >>> 1;
  localparam logic signed [ACC_W-1:0] KNEE    = ONE * 2;
  localparam logic signed [ACC_W-1:0] SAT     = ONE * 4;
  localparam logic signed [ACC_W-1:0] KNEE_Y  = (ONE * 3) >>> 2;

  function automatic logic signed [ACC_W-1:0] sigm_pwl(input logic signed [ACC_W-1:0] x);
    if (x >= SAT)       return ONE;
    else if (x <= -SAT) return '0;
    else                return HALF + (x >>> 3);
  endfunction

  function automatic logic signed [ACC_W-1:0] tanh_pwl(input logic signed [ACC_W-1:0] x);
    logic signed [ACC_W-1:0] mag;
    logic signed [ACC_W-1:0] seg;
    if (x >= SAT)       return ONE;
    else if (x <= -SAT) return -ONE;
    mag = (x < 0) ? -x : x;
    if (mag < KNEE) seg = (mag * 3) >>> 3;
    else            seg = KNEE_Y + ((mag - KNEE) >>> 3);
    return (x < 0) ? -seg : seg;
  endfunction

  function automatic logic signed [ACC_W-1:0] act_eval(input logic signed [ACC_W-1:0] x,
                                                      input act_fn_e f);
    case (f)
      FN_RECT: return (x < 0) ? '0 : x;
      FN_SIGM: return sigm_pwl(x);
      FN_TANH: return tanh_pwl(x);
      default: return x;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o   <= 1'b0;
      act_o   <= '0;
      min_o   <= '0;
      scale_o <= '0;
    end else if (adv) begin
      vld_o <= load;
      if (load) begin
        act_o   <= act_eval(acc_i, act_fn_e'(fn_i));
        min_o   <= min_i;
        scale_o <= scale_i;
      end
    end
  end

  // R2: pass-through keeps the sum
  p_pass_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && load && fn_i == 2'b00) |=> (act_o == $past(acc_i)));

  // R3: rectifier never yields a negative value
  p_rect_nonneg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && load && fn_i == 2'b01) |=> (act_o >= 0));

  // R4: sigmoid stays within 0..1.0
  p_sigm_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && load && fn_i == 2'b10) |=> (act_o >= 0 && act_o <= ONE));

  // R5: tanh stays within -1.0..1.0
  p_tanh_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && load && fn_i == 2'b11) |=> (act_o >= -ONE && act_o <= ONE));

endmodule

// File: rtl/actq_scale_stage.sv
module actq_scale_stage #(
  parameter int ACC_W   = 32,
  parameter int SCALE_W = 24,
  parameter int PROD_W  = ACC_W + SCALE_W + 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      adv,
  input  logic                      vld_i,
  input  logic signed [ACC_W-1:0]   act_i,
  input  logic signed [ACC_W-1:0]   min_i,
  input  logic [SCALE_W-1:0]        scale_i,
  output logic                      vld_o,
  output logic signed [PROD_W-1:0]  prod_o
);
  localparam int DIFF_W = ACC_W + 1;

  function automatic logic signed [PROD_W-1:0] offset_gain(input logic signed [ACC_W-1:0] y,
                                                          input logic signed [ACC_W-1:0] lo,
                                                          input logic [SCALE_W-1:0] g);
    logic signed [DIFF_W-1:0]  d;
    logic signed [SCALE_W:0]   gs;
    logic signed [PROD_W-1:0]  p;
    d  = DIFF_W'(y) - DIFF_W'(lo);
    gs = $signed({1'b0, g});
    p  = d * gs;
    return p;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      prod_o <= '0;
    end else if (adv) begin
      vld_o <= vld_i;
      if (vld_i) prod_o <= offset_gain(act_i, min_i, scale_i);
    end
  end

endmodule

// File: rtl/actq_clamp_stage.sv
module actq_clamp_stage #(
  parameter int PROD_W     = 58,
  parameter int SCALE_FRAC = 16,
  parameter int CODE_W     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      adv,
  input  logic                      vld_i,
  input  logic signed [PROD_W-1:0]  prod_i,
  output logic                      vld_o,
  output logic [CODE_W-1:0]         code_o
);
  localparam logic signed [PROD_W:0] RND_BIAS = (PROD_W+1)'(1) <<< (SCALE_FRAC - 1);
  localparam logic signed [PROD_W:0] CODE_TOP = (PROD_W+1)'((1 << CODE_W) - 1);

  function automatic logic [CODE_W-1:0] round_clamp(input logic signed [PROD_W-1:0] p);
    logic signed [PROD_W:0] r;
    r = ((PROD_W+1)'(p) + RND_BIAS) >>> SCALE_FRAC;
    if (r < 0)             return '0;
    else if (r > CODE_TOP) return '1;
    else                   return r[CODE_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      code_o <= '0;
    end else if (adv) begin
      vld_o <= vld_i;
      if (vld_i) code_o <= round_clamp(prod_i);
    end
  end

endmodule

// File: rtl/actq_pipe.sv
module actq_pipe #(
  parameter int ACC_W      = 32,
  parameter int FRAC       = 8,
  parameter int SCALE_W    = 24,
  parameter int SCALE_FRAC = 16,
  parameter int CODE_W     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [ACC_W-1:0]    in_acc,
  input  logic [1:0]          in_fn,
  input  logic [ACC_W-1:0]    in_min,
  input  logic [SCALE_W-1:0]  in_scale,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [CODE_W-1:0]   out_code
);
  localparam int PROD_W = ACC_W + SCALE_W + 2;

  logic                      adv_fn, adv_sc, adv_cl;
  logic                      vld_fn, vld_sc;
  logic                      in_fire;
  logic signed [ACC_W-1:0]   act_fn, min_fn;
  logic [SCALE_W-1:0]        scale_fn;
  logic signed [PROD_W-1:0]  prod_sc;

  assign adv_cl   = !out_valid || out_ready;
  assign adv_sc   = !vld_sc || adv_cl;
  assign adv_fn   = !vld_fn || adv_sc;
  assign in_ready = adv_fn;
  assign in_fire  = in_valid && in_ready;

  actq_fn_stage #(.ACC_W(ACC_W), .FRAC(FRAC), .SCALE_W(SCALE_W)) u_fn (
    .clk(clk), .rst_n(rst_n), .adv(adv_fn), .load(in_fire),
    .acc_i($signed(in_acc)), .fn_i(in_fn), .min_i($signed(in_min)), .scale_i(in_scale),
    .vld_o(vld_fn), .act_o(act_fn), .min_o(min_fn), .scale_o(scale_fn)
  );

  actq_scale_stage #(.ACC_W(ACC_W), .SCALE_W(SCALE_W), .PROD_W(PROD_W)) u_sc (
    .clk(clk), .rst_n(rst_n), .adv(adv_sc), .vld_i(vld_fn),
    .act_i(act_fn), .min_i(min_fn), .scale_i(scale_fn),
    .vld_o(vld_sc), .prod_o(prod_sc)
  );

  actq_clamp_stage #(.PROD_W(PROD_W), .SCALE_FRAC(SCALE_FRAC), .CODE_W(CODE_W)) u_cl (
    .clk(clk), .rst_n(rst_n), .adv(adv_cl), .vld_i(vld_sc), .prod_i(prod_sc),
    .vld_o(out_valid), .code_o(out_code)
  );

  // R10: a stalled output holds its code
  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));

  // R10: an empty output stage always lets a beat in
  p_ready_if_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid) |-> in_ready);

endmodule

// File: tb/actq_pipe_tb_top.sv
module actq_pipe_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_acc = '0;
  logic [1:0]  in_fn = '0;
  logic [31:0] in_min = '0;
  logic [23:0] in_scale = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_code;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int stalls = 0;
  bit lat_chk = 0;
  string cur_tag = "";

  int    exp_q[$];
  string tag_q[$];
  int    stamp_q[$];

  always #10 clk = ~clk;

  actq_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .in_fn(in_fn), .in_min(in_min), .in_scale(in_scale),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code)
  );

  function automatic longint model_act(longint x, int f);
    longint m, s;
    case (f)
      1: return (x < 0) ? 0 : x;
      2: begin
        if (x >= 1024) return 256;
        if (x <= -1024) return 0;
        return 128 + ((x + 8192) / 8 - 1024);
      end
      3: begin
        if (x >= 1024) return 256;
        if (x <= -1024) return -256;
        m = (x < 0) ? -x : x;
        if (m < 512) s = (3 * m) / 8;
        else         s = 192 + (m - 512) / 8;
        return (x < 0) ? -s : s;
      end
      default: return x;
    endcase
  endfunction

  function automatic int model_code(longint x, int f, longint lo, longint g);
    longint p, q, n;
    p = (model_act(x, f) - lo) * g + 32768;
    n = p / 65536;
    if (p < 0 && n * 65536 != p) n = n - 1;
    q = n;
    if (q < 0) return 0;
    if (q > 255) return 255;
    return int'(q);
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R10 unexpected output", out_code, -1);
      end else begin
        int e, st;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        st = stamp_q.pop_front();
        check(out_code == e[7:0], t, out_code, e);
        if (lat_chk) check(cyc - st == 3, "R9 latency", cyc - st, 3);
      end
    end
    if (rst_n && in_valid && in_ready) begin
      exp_q.push_back(model_code(longint'($signed(in_acc)), int'(in_fn),
                                 longint'($signed(in_min)), longint'(in_scale)));
      tag_q.push_back(cur_tag);
      stamp_q.push_back(cyc);
    end
  end

  task automatic send(int acc, int f, int lo, int g, string tag);
    in_acc = acc; in_fn = f[1:0]; in_min = lo; in_scale = g[23:0];
    cur_tag = tag; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) begin stalls++; @(negedge clk); end
    @(posedge clk); #2;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk); #2;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_pass_r2();
    send(100, 0, 0, 65536, "R2 pass 100");
    send(37, 0, 0, 65536, "R2 pass 37");
    send(-200, 0, -256, 32640, "R2 pass negative");
    drain();
  endtask

  task automatic t_rect_r3();
    send(-50, 1, 0, 65536, "R3 rect negative");
    send(77, 1, 0, 65536, "R3 rect positive");
    send(0, 1, 0, 65536, "R3 rect zero");
    send(-2147483647 - 1, 1, -10, 65536, "R3 rect most negative");
    drain();
  endtask

  task automatic t_sigm_r4();
    send(0, 2, 0, 65536, "R4 sigmoid zero");
    send(-9, 2, 0, 65536, "R4 sigmoid floor");
    send(1023, 2, 0, 65536, "R4 sigmoid below limit");
    send(1024, 2, 0, 65280, "R4 sigmoid high limit");
    send(-1024, 2, 0, 65536, "R4 sigmoid low limit");
    send(-2147483647 - 1, 2, 0, 65536, "R4 sigmoid far low");
    drain();
  endtask

  task automatic t_tanh_r5();
    send(100, 3, -256, 32640, "R5 tanh inner");
    send(-100, 3, -256, 32640, "R5 tanh inner neg");
    send(700, 3, -256, 32640, "R5 tanh outer");
    send(-700, 3, -256, 32640, "R5 tanh outer neg");
    send(512, 3, -256, 32640, "R5 tanh knee");
    send(5000, 3, -256, 32640, "R5 tanh high sat");
    send(-2147483647 - 1, 3, -256, 32640, "R5 tanh low sat");
    send(-700, 3, -300, 65536, "R5 tanh outer exact");
    drain();
  endtask

  task automatic t_requant_r6();
    send(1000, 0, 900, 131072, "R6 gain 2");
    send(-1000, 0, -1100, 40000, "R6 offset negative");
    send(300, 0, 200, 98304, "R6 gain 1.5");
    drain();
  endtask

  task automatic t_clamp_r7();
    send(300, 0, 0, 65536, "R7 clamp high");
    send(-5, 0, 0, 65536, "R7 clamp low");
    send(2147483647, 0, -2147483647 - 1, 16777215, "R7 clamp extreme");
    drain();
  endtask

  task automatic t_round_r8();
    send(3, 0, 0, 32768, "R8 half rounds up 1.5");
    send(1, 0, 0, 32768, "R8 half rounds up 0.5");
    send(2, 0, 0, 32768, "R8 exact 1");
    send(-1, 0, 0, 32768, "R8 minus half to 0");
    drain();
  endtask

  task automatic t_latency_r9();
    out_ready = 1'b1;
    drain();
    lat_chk = 1;
    stalls = 0;
    for (int k = 0; k < 6; k++) send(10 * k, 0, 0, 65536, "R9 stream");
    check(stalls == 0, "R9 back-to-back stalls", stalls, 0);
    drain();
    lat_chk = 0;
  endtask

  task automatic t_stall_r10();
    logic [7:0] held;
    out_ready = 1'b0;
    send(11, 0, 0, 65536, "R10 order 1");
    send(22, 0, 0, 65536, "R10 order 2");
    send(33, 0, 0, 65536, "R10 order 3");
    in_acc = 44; in_fn = 2'b00; in_min = 0; in_scale = 24'd65536;
    cur_tag = "R10 order 4"; in_valid = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0, "R10 ready low when full", in_ready, 0);
    check(out_valid == 1'b1, "R10 valid while stalled", out_valid, 1);
    held = out_code;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_code == held, "R10 code stable", out_code, held);
    end
    @(posedge clk); #2;
    out_ready = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #2;
    in_valid = 1'b0;
    drain();
  endtask

  task automatic t_mixed_r11();
    send(-300, 1, 0, 65536, "R11 mixed rect");
    send(-300, 0, -400, 65536, "R11 mixed pass");
    send(-300, 2, 0, 65536, "R11 mixed sigmoid");
    send(-300, 3, -256, 32640, "R11 mixed tanh");
    send(-300, 0, -300, 131072, "R11 mixed gain");
    drain();
  endtask

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_pass_r2();
    t_rect_r3();
    t_sigm_r4();
    t_tanh_r5();
    t_requant_r6();
    t_clamp_r7();
    t_round_r8();
    t_latency_r9();
    t_stall_r10();
    t_mixed_r11();
    repeat (4) @(posedge clk);
    check(exp_q.size() == 0, "R10 no beat lost", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule